// File: doc/BRIEF.md
# Polling Receiver Wake-Up Sequencer

This block sets the timing and power cycling of a duty-cycled radio receiver. A prescaler divides the oscillator clock into a basic clock-enable tick. The divide ratio is 10 or 14, chosen by a region-select pin. A second counter turns every 8th, 4th, 2nd or every basic tick into a slower sub-tick, picked by a 2-bit baud-range code.

On these ticks a state machine runs a polling loop with four states: SLEEP, STARTUP, CHECK and RECEIVE. SLEEP lasts a programmed number of basic ticks. STARTUP lasts a programmed number of basic ticks. CHECK waits for an external bit-check verdict, with a limit counted in sub-ticks. The named transitions are:
- sleep_done: SLEEP to STARTUP, when the sleep count expires.
- settle_done: STARTUP to CHECK, when the start-up count expires.
- check_pass: CHECK to RECEIVE, on a valid verdict.
- check_fail: CHECK to SLEEP, on an invalid verdict.
- check_timeout: CHECK to SLEEP, when the sub-tick limit is reached.
- rx_done: RECEIVE to SLEEP, when the release input is asserted.

The block drives the signal-processing enable, a polling-activity flag, a receive flag and the phase code.

Top module: `poll_wake_seq`

## Requirements
- R1: `base_tick` is a one-cycle pulse. It repeats every 10 clocks while `region_hi`=0 and every 14 clocks while `region_hi`=1.
- R2: In the cycle where `region_hi` differs from its value at the previous edge, `base_tick` is 0. The next `base_tick` comes exactly N cycles after that cycle, where N is the new ratio.
- R3: `sub_tick` occurs only together with `base_tick`. It marks every 8th, 4th, 2nd or every basic tick for `baud_code` 0, 1, 2 and 3.
- R4: `phase` encodes SLEEP=0, STARTUP=1, CHECK=2 and RECEIVE=3. The polling order is SLEEP, then STARTUP, then CHECK.
- R5: SLEEP lasts `sleep_len` basic ticks and STARTUP lasts `start_len` basic ticks. Each length is sampled when its phase is entered, and a length of 0 acts as 1. The phase is left in the cycle after its last counted tick.
- R6: `sp_enable` is 0 in SLEEP and 1 in every other phase.
- R7: `active` is 1 only in STARTUP and CHECK. `rx_on` is 1 only in RECEIVE.
- R8: In CHECK, `chk_result`=01 (valid) moves to RECEIVE on the next cycle. `chk_result`=10 (invalid) moves to SLEEP on the next cycle. Codes 00 and 11 mean still checking.
- R9: If `check_max` sub-ticks (sampled on entry to CHECK, 0 acting as 1) pass in CHECK without a verdict, the block returns to SLEEP.
- R10: RECEIVE holds until `rx_release`=1 and then returns to SLEEP. `rx_release` has no effect in other phases.
- R11: A synchronous `rst` puts the block in SLEEP with all counters cleared and the tick counters restarted.
- R12: `chk_result` has no effect outside CHECK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | oscillator clock |
| rst | input | 1 | synchronous reset, active high |
| region_hi | input | 1 | 1 selects ÷14, 0 selects ÷10 |
| baud_code | input | 2 | sub-tick ratio select |
| sleep_len | input | SLEEP_W | sleep length in basic ticks |
| start_len | input | SLEEP_W | start-up length in basic ticks |
| check_max | input | CHECK_W | check limit in sub-ticks |
| chk_result | input | 2 | 00/11 checking, 01 valid, 10 invalid |
| rx_release | input | 1 | leave RECEIVE |
| base_tick | output | 1 | basic tick pulse |
| sub_tick | output | 1 | secondary tick pulse |
| phase | output | 2 | current phase code |
| sp_enable | output | 1 | signal-processing enable |
| active | output | 1 | polling active (STARTUP or CHECK) |
| rx_on | output | 1 | receive state |

## Verification
The ticks are combinational from the prescaler and sub-tick registers and from the present `region_hi` and `baud_code`. They are therefore due in the same cycle as those inputs. The phase outputs change one clock after the tick or verdict that causes them.

The bench drives inputs just after the falling edge. Its reference model advances on the rising edge. It compares every output a short delay after each falling edge, so both sides have settled. The targeted checks count cycles or ticks from an observed event under the same rule.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [1:0] {
        PH_SLEEP = 2'd0,
        PH_START = 2'd1,
        PH_CHECK = 2'd2,
        PH_RECV  = 2'd3
    } phase_t;

    localparam logic [1:0] CHK_BUSY = 2'b00;
    localparam logic [1:0] CHK_PASS = 2'b01;
    localparam logic [1:0] CHK_FAIL = 2'b10;
endpackage

// File: rtl/pw_prescaler.sv
module pw_prescaler #(
    parameter int DIV_LO = 10,
    parameter int DIV_HI = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_hi,
    output logic tick_o
);
    localparam int MAXD = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
    localparam int CNTW = $clog2(MAXD);

    logic [CNTW-1:0] cnt;
    logic [CNTW-1:0] lim;
    logic            sel_q;
    logic            chg;

    always_comb begin
        lim    = sel_hi ? CNTW'(DIV_HI - 1) : CNTW'(DIV_LO - 1);
        chg    = (sel_hi != sel_q);
        tick_o = !chg && (cnt >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            sel_q <= sel_hi;
        end else begin
            sel_q <= sel_hi;
            if (chg || tick_o) cnt <= '0;
            else               cnt <= cnt + 1'b1;
        end
    end

    // R1
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
endmodule

// File: rtl/pw_subtick.sv
module pw_subtick #(
    parameter int BAUD_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_tick,
    input  logic [BAUD_W-1:0] baud,
    output logic              tick_o
);
    localparam int RW  = 2**BAUD_W - 1;
    localparam int SCW = (RW > 0) ? RW : 1;

    logic [SCW-1:0] sc;
    logic [SCW:0]   ratio;
    logic [SCW:0]   term;

    always_comb begin
        ratio  = {1'b1, {SCW{1'b0}}} >> baud;
        term   = ratio - 1'b1;
        tick_o = base_tick && ({1'b0, sc} >= term);
    end

    always_ff @(posedge clk) begin
        if (rst)            sc <= '0;
        else if (base_tick) sc <= tick_o ? '0 : sc + 1'b1;
    end

    // R3
    sub_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
endmodule

// File: rtl/pw_fsm.sv
module pw_fsm
    import pw_pkg::*;
#(
    parameter int SW = 12,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          base_tick,
    input  logic          sub_tick,
    input  logic [1:0]    chk_result,
    input  logic          rx_release,
    input  logic [SW-1:0] sleep_len,
    input  logic [SW-1:0] start_len,
    input  logic [CW-1:0] check_max,
    output logic [1:0]    phase_o,
    output logic          sp_en_o,
    output logic          active_o,
    output logic          rx_on_o
);
    phase_t        state, state_nx;
    logic [SW-1:0] tmr, len_q;
    logic [CW-1:0] scnt, lim_q;
    logic          tmr_done, chk_to;

    always_comb begin
        tmr_done = base_tick && (({1'b0, tmr} + 1'b1) >= {1'b0, len_q});
        chk_to   = sub_tick && (({1'b0, scnt} + 1'b1) >= {1'b0, lim_q});
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_SLEEP: if (tmr_done) state_nx = PH_START;   // sleep_done
            PH_START: if (tmr_done) state_nx = PH_CHECK;   // settle_done
            PH_CHECK: begin
                if (chk_result == CHK_PASS)      state_nx = PH_RECV;  // check_pass
                else if (chk_result == CHK_FAIL) state_nx = PH_SLEEP; // check_fail
                else if (chk_to)                 state_nx = PH_SLEEP; // check_timeout
            end
            PH_RECV:  if (rx_release) state_nx = PH_SLEEP; // rx_done
            default:  state_nx = PH_SLEEP;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= PH_SLEEP;
        else     state <= state_nx;
    end

    // phase timers
    always_ff @(posedge clk) begin
        if (rst) begin
            tmr   <= '0;
            scnt  <= '0;
            len_q <= sleep_len;
            lim_q <= '0;
        end else if (state_nx != state) begin
            tmr  <= '0;
            scnt <= '0;
            unique case (state_nx)
                PH_SLEEP: len_q <= sleep_len;
                PH_START: len_q <= start_len;
                PH_CHECK: lim_q <= check_max;
                default:  ;
            endcase
        end else begin
            if ((state == PH_SLEEP || state == PH_START) && base_tick) tmr <= tmr + 1'b1;
            if (state == PH_CHECK && sub_tick) scnt <= scnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        phase_o = state;
        unique case (state)
            PH_SLEEP: begin sp_en_o = 1'b0; active_o = 1'b0; rx_on_o = 1'b0; end
            PH_START: begin sp_en_o = 1'b1; active_o = 1'b1; rx_on_o = 1'b0; end
            PH_CHECK: begin sp_en_o = 1'b1; active_o = 1'b1; rx_on_o = 1'b0; end
            PH_RECV:  begin sp_en_o = 1'b1; active_o = 1'b0; rx_on_o = 1'b1; end
            default:  begin sp_en_o = 1'b0; active_o = 1'b0; rx_on_o = 1'b0; end
        endcase
    end

    // R4
    sleep_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_SLEEP) |=> (state == PH_SLEEP || state == PH_START));
    // R4
    start_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_START) |=> (state == PH_START || state == PH_CHECK));
    // R5
    sleep_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_SLEEP && !base_tick) |=> (state == PH_SLEEP));
    // R8
    pass_recv_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_CHECK && chk_result == CHK_PASS) |=> (state == PH_RECV));
    // R10
    recv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_RECV && !rx_release) |=> (state == PH_RECV));
endmodule

// File: rtl/poll_wake_seq.sv
module poll_wake_seq #(
    parameter int DIV_LO  = 10,
    parameter int DIV_HI  = 14,
    parameter int BAUD_W  = 2,
    parameter int SLEEP_W = 12,
    parameter int CHECK_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               region_hi,
    input  logic [BAUD_W-1:0]  baud_code,
    input  logic [SLEEP_W-1:0] sleep_len,
    input  logic [SLEEP_W-1:0] start_len,
    input  logic [CHECK_W-1:0] check_max,
    input  logic [1:0]         chk_result,
    input  logic               rx_release,
    output logic               base_tick,
    output logic               sub_tick,
    output logic [1:0]         phase,
    output logic               sp_enable,
    output logic               active,
    output logic               rx_on
);
    pw_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
        .clk(clk), .rst(rst), .sel_hi(region_hi), .tick_o(base_tick));

    pw_subtick #(.BAUD_W(BAUD_W)) u_sub (
        .clk(clk), .rst(rst), .base_tick(base_tick), .baud(baud_code), .tick_o(sub_tick));

    pw_fsm #(.SW(SLEEP_W), .CW(CHECK_W)) u_fsm (
        .clk(clk), .rst(rst), .base_tick(base_tick), .sub_tick(sub_tick),
        .chk_result(chk_result), .rx_release(rx_release),
        .sleep_len(sleep_len), .start_len(start_len), .check_max(check_max),
        .phase_o(phase), .sp_en_o(sp_enable), .active_o(active), .rx_on_o(rx_on));

    // R3
    sub_with_base_chk: assert property (@(posedge clk) disable iff (rst)
        sub_tick |-> base_tick);
endmodule

// File: tb/sim_poll_wake_seq.sv
module sim_poll_wake_seq;
    localparam int CLK_PER = 10;

    logic        clk = 0, rst = 1, region_hi = 0, rx_release = 0;
    logic [1:0]  baud_code = 0, chk_result = 0;
    logic [11:0] sleep_len = 3, start_len = 2;
    logic [7:0]  check_max = 4;
    logic        base_tick, sub_tick, sp_enable, active, rx_on;
    logic [1:0]  phase;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    poll_wake_seq u0 (.*);

    always #(CLK_PER/2) clk = ~clk;

    // behavioural reference
    int m_cnt = 0, m_sc = 0, m_tmr = 0, m_len = 0, m_scnt = 0, m_lim = 0, m_ph = 0;
    bit m_sel = 0;

    function automatic bit m_btick();
        int lim = region_hi ? 13 : 9;
        return (m_sel == region_hi) && (m_cnt >= lim);
    endfunction
    function automatic bit m_stick();
        int r = 8 >> baud_code;
        return m_btick() && (m_sc >= r - 1);
    endfunction

    always @(posedge clk) begin
        bit b, s;
        b = m_btick(); s = m_stick();
        if (rst) begin
            m_cnt = 0; m_sel = region_hi; m_sc = 0; m_ph = 0;
            m_tmr = 0; m_len = int'(sleep_len); m_scnt = 0; m_lim = 0;
        end else begin
            case (m_ph)
                0, 1: if (b) begin
                    if (m_tmr + 1 >= m_len) begin
                        m_tmr = 0;
                        if (m_ph == 0) begin m_ph = 1; m_len = int'(start_len); end
                        else begin m_ph = 2; m_scnt = 0; m_lim = int'(check_max); end
                    end else m_tmr++;
                end
                2: begin
                    if (chk_result == 2'b01) m_ph = 3;
                    else if (chk_result == 2'b10) begin m_ph = 0; m_tmr = 0; m_len = int'(sleep_len); end
                    else if (s) begin
                        if (m_scnt + 1 >= m_lim) begin m_ph = 0; m_tmr = 0; m_len = int'(sleep_len); end
                        else m_scnt++;
                    end
                end
                default: if (rx_release) begin m_ph = 0; m_tmr = 0; m_len = int'(sleep_len); end
            endcase
            if (m_sel != region_hi || b) m_cnt = 0; else m_cnt++;
            m_sel = region_hi;
            if (b) m_sc = s ? 0 : m_sc + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            chk(base_tick == m_btick(), "R1/R2 base_tick", base_tick, m_btick());
            chk(sub_tick == m_stick(), "R3 sub_tick", sub_tick, m_stick());
            chk(int'(phase) == m_ph, "R4/R8/R9 phase", phase, m_ph);
            chk(sp_enable == (m_ph != 0), "R6 sp_enable", sp_enable, m_ph != 0);
            chk(active == (m_ph == 1 || m_ph == 2), "R7 active", active, m_ph == 1 || m_ph == 2);
            chk(rx_on == (m_ph == 3), "R7 rx_on", rx_on, m_ph == 3);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !done) begin
            done = 1; bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(); @(negedge clk); #2; endtask

    task automatic wait_phase(input int p, input string req);
        int n = 0;
        while (int'(phase) != p && n < 5000) begin step(); n++; end
        chk(int'(phase) == p, req, phase, p);
    endtask

    task automatic tick_gap(output int g);
        int n = 0;
        while (!base_tick && n < 100) begin step(); n++; end
        g = 0;
        do begin step(); g++; end while (!base_tick && g < 100);
    endtask

    initial begin
        int g, n;
        repeat (3) step();
        chk(phase == 2'd0 && !sp_enable && !active && !rx_on, "R11 reset state", phase, 0);
        rst = 0;
        tick_gap(g); chk(g == 10, "R1 gap lo", g, 10);
        repeat (400) step();
        region_hi = 1;
        tick_gap(g); chk(g == 14, "R1 gap hi", g, 14);
        repeat (4) step();
        region_hi = 0; #0;
        chk(base_tick == 0, "R2 no tick on change", base_tick, 0);
        g = 0;
        do begin step(); g++; end while (!base_tick && g < 100);
        chk(g == 10, "R2 resync", g, 10);
        // R12: pass verdict during sleep has no effect
        check_max = 40;
        wait_phase(0, "R12 sleep");
        chk_result = 2'b01;
        wait_phase(1, "R12 startup reached");
        chk(phase == 2'd1, "R12 not receive", phase, 1);
        chk_result = 2'b00;
        // R8 pass
        wait_phase(2, "R4 check");
        chk_result = 2'b01; step();
        chk(phase == 2'd3, "R8 pass", phase, 3);
        chk_result = 2'b10; repeat (20) step();
        chk(phase == 2'd3, "R10 hold receive", phase, 3);
        chk_result = 2'b00; rx_release = 1; step();
        chk(phase == 2'd0, "R10 release", phase, 0);
        wait_phase(1, "R10 release ignored in sleep");
        rx_release = 0;
        // R8 fail
        wait_phase(2, "R4 check again");
        chk_result = 2'b10; step();
        chk(phase == 2'd0, "R8 fail", phase, 0);
        chk_result = 2'b00;
        // R5 sleep length, then 0 acting as 1
        sleep_len = 5;
        wait_phase(2, "R5 check");
        chk_result = 2'b10; step(); chk_result = 2'b00;
        n = 0;
        while (phase == 2'd0 && n < 5000) begin if (base_tick) n++; step(); end
        chk(n == 5, "R5 sleep len", n, 5);
        sleep_len = 0;
        wait_phase(2, "R5 check 2");
        chk_result = 2'b10; step(); chk_result = 2'b00;
        n = 0;
        while (phase == 2'd0 && n < 5000) begin if (base_tick) n++; step(); end
        chk(n == 1, "R5 zero sleep", n, 1);
        // R3 / R9 with other baud codes
        sleep_len = 2; check_max = 3;
        for (int c = 1; c < 4; c++) begin
            baud_code = 2'(c);
            repeat (500) step();
        end
        baud_code = 2;
        n = 0;
        while (!sub_tick && n < 500) begin step(); n++; end
        n = 0;
        do begin step(); if (base_tick) n++; end while (!sub_tick && n < 50);
        chk(n == 2, "R3 code2 ratio", n, 2);
        // R11 mid-run reset
        rst = 1; step(); rst = 0;
        chk(phase == 2'd0, "R11 reset mid-run", phase, 0);
        repeat (300) step();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule